// File: doc/BRIEF.md
# Branch Condition Mask Evaluator

This block decides whether a conditional branch is taken and computes where it goes. A 2-bit condition code register holds the outcome of the last compare or arithmetic step. It is written through a strobe by the execution logic. When an instruction word is presented, the block decodes it as one of two branch formats. The long format carries an index register, a base register and a 12-bit displacement. The short format names one register whose contents are the target.

Both formats carry a 4-bit condition mask. Each mask bit stands for one condition code value. If the bit for the current code is set, the branch is taken. The block asks the register file for the operands it needs through two select outputs, and reads the data back combinationally on two input ports. One cycle after the instruction is presented, it registers the decision and a 24-bit target.

Top module: `brcond_eval`

## Requirements
- R1: After reset, `cc_q` is 0, `br_valid` is 0, `br_taken` is 0 and `br_target` is 0.
- R2: When `cc_we` is high at a clock edge, `cc_q` takes `cc_wdata` from that edge on. Otherwise `cc_q` holds its value. Code 0 means equal/zero, 1 means low/negative, 2 means high/positive and 3 means overflow.
- R3: The mask is `insn[23:20]`. Its bits are numbered 0 to 3 from the most significant bit. A branch is taken when the mask bit numbered by `cc_q` is set, so mask 8 selects code 0 and mask 1 selects code 3. For example, mask 7 branches on not-equal, 11 on not-low, 13 on not-high and 14 on no-overflow.
- R4: A mask of 0 never branches. A mask of 15 always branches, except in the case of R9.
- R5: The decision uses the condition code held before any write made at the same clock edge.
- R6: The long format has `insn[31:24]` = 0x47, index register `insn[19:16]`, base register `insn[15:12]` and displacement `insn[11:0]`. Its target is base contents plus index contents plus the zero-extended displacement, truncated to the low 24 bits.
- R7: In the long format, an index or base register number of 0 contributes zero to the sum, whatever data the register file returns.
- R8: The short format has `insn[31:24]` = 0x07, mask `insn[23:20]` and register `insn[19:16]`. Its target is the low 24 bits of that register's contents. Bits `insn[15:0]` are ignored.
- R9: In the short format, a register number of 0 suppresses the branch whatever the mask.
- R10: An instruction with any other opcode produces no result: `br_valid` stays 0, and `br_taken` and `br_target` hold their values.
- R11: Results appear one cycle after `insn_valid`, with `br_valid` high for exactly that cycle. `br_taken` and `br_target` hold their values when no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cc_we | input | 1 | Condition code write strobe |
| cc_wdata | input | 2 | New condition code value |
| insn_valid | input | 1 | Instruction word present |
| insn | input | 32 | Instruction word, first byte in bits 31:24 |
| rf_sel_x | output | 4 | Register file select for the index operand |
| rf_sel_b | output | 4 | Register file select for the base or short-format register |
| rf_x_data | input | 32 | Contents of register `rf_sel_x` |
| rf_b_data | input | 32 | Contents of register `rf_sel_b` |
| cc_q | output | 2 | Current condition code |
| br_valid | output | 1 | Branch result valid |
| br_taken | output | 1 | Branch taken |
| br_target | output | 24 | Branch target address |

## Verification
The mask test is swept over all 16 masks against all four condition codes. This separates a mask read from the wrong end from a correct one, because the two readings agree only on symmetric masks. Random register contents with the top bits set, together with random displacements, show whether the long-format sum is truncated correctly and whether the index and base terms are added. Register 0 is loaded with non-zero garbage in the model, which exposes any path that forwards its data instead of zero. Strobed condition-code writes that land in the same cycle as a branch show whether the old or the new code decides it. Random opcodes check that unknown words leave the outputs untouched.

// File: rtl/brcond_eval.sv
module brcond_eval #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int SEL_W  = 4,
  parameter int DISP_W = 12,
  parameter logic [7:0] OPC_LONG  = 8'h47,
  parameter logic [7:0] OPC_SHORT = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cc_we,
  input  logic [1:0]        cc_wdata,
  input  logic              insn_valid,
  input  logic [31:0]       insn,
  output logic [SEL_W-1:0]  rf_sel_x,
  output logic [SEL_W-1:0]  rf_sel_b,
  input  logic [DATA_W-1:0] rf_x_data,
  input  logic [DATA_W-1:0] rf_b_data,
  output logic [1:0]        cc_q,
  output logic              br_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target
);
  localparam logic [SEL_W-1:0] NOREG = '0;

  logic [7:0]        opc;
  logic [3:0]        mask;
  logic [SEL_W-1:0]  r_a, r_b;
  logic [DISP_W-1:0] disp;
  logic              is_long, is_short, hit, take_d;
  logic [DATA_W-1:0] x_term, b_term, sum;
  logic [ADDR_W-1:0] tgt_d;

  assign opc  = insn[31:24];
  assign mask = insn[23:20];
  assign r_a  = insn[19:16];
  assign r_b  = insn[15:12];
  assign disp = insn[DISP_W-1:0];

  assign is_long  = opc == OPC_LONG;
  assign is_short = opc == OPC_SHORT;

  assign rf_sel_x = r_a;
  assign rf_sel_b = is_short ? r_a : r_b;

  assign x_term = (r_a != NOREG) ? rf_x_data : '0;
  assign b_term = (r_b != NOREG) ? rf_b_data : '0;
  assign sum    = x_term + b_term + DATA_W'(disp);

  assign hit    = mask[2'd3 - cc_q];
  assign take_d = hit && !(is_short && r_a == NOREG);
  assign tgt_d  = is_short ? rf_b_data[ADDR_W-1:0] : sum[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q      <= '0;
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
    end else begin
      if (cc_we) cc_q <= cc_wdata;
      br_valid <= insn_valid && (is_long || is_short);
      if (insn_valid && (is_long || is_short)) begin
        br_taken  <= take_d;
        br_target <= tgt_d;
      end
    end
  end
endmodule

module brcond_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cc_we,
  input logic [1:0]  cc_wdata,
  input logic        insn_valid,
  input logic [31:0] insn,
  input logic [1:0]  cc_q,
  input logic        br_valid,
  input logic        br_taken,
  input logic [23:0] br_target
);
  logic known;
  assign known = insn[31:24] == 8'h47 || insn[31:24] == 8'h07;

  AST_CC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |=> cc_q == $past(cc_wdata)); // R2
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_we |=> $stable(cc_q)); // R2
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && known && insn[23:20] == 4'h0) |=> br_valid && !br_taken); // R4
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[31:24] == 8'h47 && insn[23:20] == 4'hF) |=> br_taken); // R4
  AST_SHORT_R0: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[31:24] == 8'h07 && insn[19:16] == 4'h0) |=> !br_taken); // R9
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_valid && known) |=> !br_valid && $stable(br_taken) && $stable(br_target)); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && known) |=> br_valid); // R11
endmodule

bind brcond_eval brcond_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cc_we(cc_we), .cc_wdata(cc_wdata),
  .insn_valid(insn_valid), .insn(insn), .cc_q(cc_q), .br_valid(br_valid),
  .br_taken(br_taken), .br_target(br_target)
);

// File: tb/sim_brcond_eval.sv
module sim_brcond_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cc_we = 1'b0;
  logic [1:0]  cc_wdata = '0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [3:0]  rf_sel_x, rf_sel_b;
  logic [31:0] rf_x_data, rf_b_data;
  logic [1:0]  cc_q;
  logic        br_valid, br_taken;
  logic [23:0] br_target;
  logic [31:0] rf [16];

  int n_run = 0, n_fail = 0;
  logic [1:0]  m_cc = '0;
  logic        m_taken = 1'b0;
  logic [23:0] m_tgt = '0;

  always #2 clk = ~clk;

  assign rf_x_data = rf[rf_sel_x];
  assign rf_b_data = rf[rf_sel_b];

  brcond_eval u0 (
    .clk(clk), .rst_n(rst_n), .cc_we(cc_we), .cc_wdata(cc_wdata),
    .insn_valid(insn_valid), .insn(insn), .rf_sel_x(rf_sel_x), .rf_sel_b(rf_sel_b),
    .rf_x_data(rf_x_data), .rf_b_data(rf_b_data), .cc_q(cc_q), .br_valid(br_valid),
    .br_taken(br_taken), .br_target(br_target)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mask_hit(input logic [3:0] m, input logic [1:0] c);
    return m[3 - c];
  endfunction

  function automatic logic [31:0] regv(input logic [3:0] n);
    return n == 0 ? 32'h0 : rf[n];
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic we, input logic [1:0] wd);
    logic exp_v;
    logic [3:0] m;
    m = w[23:20];
    insn_valid = v; insn = w; cc_we = we; cc_wdata = wd;
    exp_v = v && (w[31:24] == 8'h47 || w[31:24] == 8'h07);
    if (exp_v) begin
      if (w[31:24] == 8'h47) begin
        m_taken = mask_hit(m, m_cc);
        m_tgt = 24'(regv(w[19:16]) + regv(w[15:12]) + {20'h0, w[11:0]});
      end else begin
        m_taken = mask_hit(m, m_cc) && w[19:16] != 0;
        m_tgt = rf[w[19:16]][23:0];
      end
    end
    if (we) m_cc = wd;
    @(negedge clk);
    chk(br_valid == exp_v, exp_v ? "R11 valid" : "R10 no result", 32'(br_valid), 32'(exp_v));
    chk(br_taken == m_taken, w[31:24] == 8'h07 ? "R9/R8/R3/R5 taken" : "R3/R4/R5 taken",
        32'(br_taken), 32'(m_taken));
    chk(br_target == m_tgt, w[31:24] == 8'h07 ? "R8 target" : "R6/R7 target",
        32'(br_target), 32'(m_tgt));
    chk(cc_q == m_cc, "R2 cc", 32'(cc_q), 32'(m_cc));
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rf[0] = 32'hDEAD_BEEF;
    for (int i = 1; i < 16; i++) rf[i] = $urandom;
    rf[8] = 32'h0000_1000;
    #1;
    chk(cc_q == 0, "R1 cc", 32'(cc_q), 0);
    chk(br_valid == 0 && br_taken == 0 && br_target == 0, "R1 outputs", 32'(br_target), 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 32'h0, 1'b1, 2'd1);
    step(1'b1, 32'h4770_8666, 1'b0, 2'd0);
    chk(br_target == 24'h001666, "R6 encoding", 32'(br_target), 32'h1666);
    step(1'b1, 32'h07F8_0000, 1'b0, 2'd0);
    step(1'b1, 32'h07F0_0000, 1'b0, 2'd0);
    step(1'b1, 32'h4700_0FFF, 1'b0, 2'd0);
    step(1'b1, 32'h4780_0123, 1'b1, 2'd0);
    step(1'b1, 32'h4780_0123, 1'b0, 2'd0);
    step(1'b1, 32'h1234_5678, 1'b0, 2'd0);
    for (int c = 0; c < 4; c++) begin
      step(1'b0, 32'h0, 1'b1, 2'(c));
      for (int m = 0; m < 16; m++) step(1'b1, {8'h47, 4'(m), 4'h3, 4'h5, 12'h010}, 1'b0, 2'd0);
    end
    for (int k = 0; k < 600; k++) begin
      logic [31:0] w;
      int sel;
      w = $urandom;
      sel = $urandom_range(0, 9);
      if (sel < 4) w[31:24] = 8'h47;
      else if (sel < 8) w[31:24] = 8'h07;
      step(1'($urandom_range(0, 4) != 0), w, 1'($urandom), 2'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule